// File: doc/BRIEF.md
# Interleaved DRAM Range Router

This block decides which memory node should serve a 40-bit physical request. It holds eight programmable windows. Each window is a pair of registers: a start register and an end register. Each window names one destination node. A window covers a span of the upper address bits, from 39 down to 24, and both ends of the span are inclusive. A window can also be restricted to a slice of the low address bits 14 to 12, so that several windows over the same span share the memory between nodes by interleaving.

Software sets up the windows through a plain synchronous register port that has an address, write data, a write strobe and a combinational read-back. A window carries its read and write permissions in its start register. An end register can therefore be loaded before anything is switched on, and it causes no stray matches. Each presented request gets a registered answer one cycle later. The answer is a hit flag and a 3-bit node number.

Top module: `mem_route_dec`

## Requirements
- R1: After reset every window is disabled, `cfg_rdata` reads zero at every offset, and `rsp_hit` and `rsp_node` are zero.
- R2: Window i has its start register at byte offset 8*i and its end register at offset 8*i+4. Offset bits 1:0 are ignored. In the start register, bit 0 permits reads, bit 1 permits writes, bits 10:8 are the interleave code and bits 31:16 are the first address tag. In the end register, bits 2:0 are the node, bits 10:8 are the interleave select and bits 31:16 are the last address tag. All other bits are dropped on write and read back as zero.
- R3: A window can match only when `req_addr[39:24]` is greater than or equal to the start tag and less than or equal to the end tag.
- R4: A window can match a read (`req_write`=0) only if its read bit is set, and a write (`req_write`=1) only if its write bit is set. A window whose start register was never written never matches, even when its end register is loaded.
- R5: Interleave code 000 applies no filter. Code 001 requires address bit 12 to equal select bit 0. Code 011 additionally requires address bit 14 to equal select bit 2. Code 111 requires all of address bits 14:12 to equal the select. Address bits that are not compared have no effect.
- R6: A window whose interleave code is 010, 100, 101 or 110 never matches.
- R7: When several windows match, the node of the lowest-numbered window is reported.
- R8: When no window matches, or when `req_valid` is low, `rsp_hit` is 0 and `rsp_node` is 0.
- R9: The response to a request appears on the first rising clock edge after the request is presented, and not earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 6 | Register byte offset |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Read-back of the register at `cfg_addr` |
| req_valid | input | 1 | Request present |
| req_addr | input | 40 | Request physical address |
| req_write | input | 1 | 1 = write access, 0 = read access |
| rsp_hit | output | 1 | A window matched the previous request |
| rsp_node | output | 3 | Destination node of the matching window |

## Verification
On every cycle the assertions check the register-port rules: reserved bits always read back as zero, and a written value is read back with its reserved bits stripped. They also check the response rules: a hit cannot appear without a request in the previous cycle, and a miss always reports node zero. The range bounds, the permission bits, each interleave code, the reserved codes and the priority between overlapping windows all depend on the programmed contents. These can only be shown by the bench's scenarios, which use a fixed window map with overlapping and interleaved windows.

// File: rtl/mem_route_pkg.sv
package mem_route_pkg;

    parameter int unsigned ADDR_W    = 40;
    parameter int unsigned TAG_LSB   = 24;
    parameter int unsigned REG_W     = 32;
    parameter int unsigned NODE_W    = 3;
    parameter int unsigned IL_W      = 3;
    parameter int unsigned IL_LSB    = 12;

    localparam int unsigned TAG_W    = ADDR_W - TAG_LSB;

    localparam logic [REG_W-1:0] START_KEEP = 32'hFFFF_0703;
    localparam logic [REG_W-1:0] END_KEEP   = 32'hFFFF_0707;

    typedef struct packed {
        logic [TAG_W-1:0] first;
        logic [IL_W-1:0]  il_code;
        logic             wr_ok;
        logic             rd_ok;
    } win_start_t;

    typedef struct packed {
        logic [TAG_W-1:0]  last;
        logic [IL_W-1:0]   il_sel;
        logic [NODE_W-1:0] node;
    } win_end_t;

    typedef struct packed {
        logic              legal;
        logic [IL_W-1:0]   mask;
    } il_decode_t;

    // Translate an interleave code into a compare mask on address bits 14:12.
    function automatic il_decode_t il_decode(input logic [IL_W-1:0] code);
        il_decode_t d;
        case (code)
            3'b000:  d = '{legal: 1'b1, mask: 3'b000};
            3'b001:  d = '{legal: 1'b1, mask: 3'b001};
            3'b011:  d = '{legal: 1'b1, mask: 3'b101};
            3'b111:  d = '{legal: 1'b1, mask: 3'b111};
            default: d = '{legal: 1'b0, mask: 3'b000};
        endcase
        return d;
    endfunction

    function automatic win_start_t start_from_word(input logic [REG_W-1:0] w);
        win_start_t s;
        s.first   = w[31:16];
        s.il_code = w[10:8];
        s.wr_ok   = w[1];
        s.rd_ok   = w[0];
        return s;
    endfunction

    function automatic win_end_t end_from_word(input logic [REG_W-1:0] w);
        win_end_t e;
        e.last   = w[31:16];
        e.il_sel = w[10:8];
        e.node   = w[2:0];
        return e;
    endfunction

    function automatic logic [REG_W-1:0] start_to_word(input win_start_t s);
        return {s.first, 5'b0, s.il_code, 6'b0, s.wr_ok, s.rd_ok};
    endfunction

    function automatic logic [REG_W-1:0] end_to_word(input win_end_t e);
        return {e.last, 5'b0, e.il_sel, 5'b0, e.node};
    endfunction

endpackage

// File: rtl/mem_route_regs.sv
module mem_route_regs
    import mem_route_pkg::*;
#(
    parameter int unsigned WINDOWS = 8,
    localparam int unsigned WIN_W  = $clog2(WINDOWS),
    localparam int unsigned CFG_AW = WIN_W + 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [CFG_AW-1:2] cfg_sel,
    input  logic [REG_W-1:0]  cfg_wdata,
    output logic [REG_W-1:0]  cfg_rdata,
    output win_start_t        start_q [WINDOWS],
    output win_end_t          end_q   [WINDOWS]
);

    logic [WIN_W-1:0] win_idx;
    logic             pick_end;

    assign win_idx  = cfg_sel[CFG_AW-1:3];
    assign pick_end = cfg_sel[2];

    logic unused_wdata;
    assign unused_wdata = ^{cfg_wdata[15:11], cfg_wdata[7:3]};

    for (genvar i = 0; i < WINDOWS; i++) begin : g_win
        always_ff @(posedge clk) begin
            if (rst) begin
                start_q[i] <= '0;
                end_q[i]   <= '0;
            end else if (cfg_we && win_idx == WIN_W'(i)) begin
                if (pick_end) end_q[i]   <= end_from_word(cfg_wdata);
                else          start_q[i] <= start_from_word(cfg_wdata);
            end
        end
    end

    always_comb begin
        if (pick_end) cfg_rdata = end_to_word(end_q[win_idx]);
        else          cfg_rdata = start_to_word(start_q[win_idx]);
    end

endmodule

// File: rtl/mem_route_match.sv
module mem_route_match
    import mem_route_pkg::*;
(
    input  win_start_t        win_start,
    input  win_end_t          win_end,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_write,
    output logic              hit
);

    logic [TAG_W-1:0] tag;
    logic [IL_W-1:0]  il_bits;
    il_decode_t       il;
    logic             in_span;
    logic             access_ok;
    logic             il_ok;

    assign tag     = req_addr[ADDR_W-1:TAG_LSB];
    assign il_bits = req_addr[IL_LSB+IL_W-1:IL_LSB];

    logic unused_addr;
    assign unused_addr = ^{req_addr[TAG_LSB-1:IL_LSB+IL_W], req_addr[IL_LSB-1:0]};

    always_comb begin
        il        = il_decode(win_start.il_code);
        in_span   = (tag >= win_start.first) && (tag <= win_end.last);
        access_ok = req_write ? win_start.wr_ok : win_start.rd_ok;
        il_ok     = il.legal && ((il_bits & il.mask) == (win_end.il_sel & il.mask));
        hit       = in_span && access_ok && il_ok;
    end

endmodule

// File: rtl/mem_route_pick.sv
module mem_route_pick
    import mem_route_pkg::*;
#(
    parameter int unsigned WINDOWS = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [WINDOWS-1:0] win_hit,
    input  win_end_t          end_q [WINDOWS],
    output logic              rsp_hit,
    output logic [NODE_W-1:0] rsp_node
);

    logic              any_hit;
    logic [NODE_W-1:0] win_node;

    // Scan from the top so the lowest-numbered matching window is assigned last.
    always_comb begin
        any_hit  = 1'b0;
        win_node = '0;
        for (int i = WINDOWS - 1; i >= 0; i--) begin
            if (win_hit[i]) begin
                any_hit  = 1'b1;
                win_node = end_q[i].node;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_hit  <= 1'b0;
            rsp_node <= '0;
        end else if (req_valid && any_hit) begin
            rsp_hit  <= 1'b1;
            rsp_node <= win_node;
        end else begin
            rsp_hit  <= 1'b0;
            rsp_node <= '0;
        end
    end

endmodule

// File: rtl/mem_route_dec.sv
module mem_route_dec
    import mem_route_pkg::*;
#(
    parameter int unsigned WINDOWS = 8,
    localparam int unsigned CFG_AW = $clog2(WINDOWS) + 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [REG_W-1:0]  cfg_wdata,
    output logic [REG_W-1:0]  cfg_rdata,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_write,
    output logic              rsp_hit,
    output logic [NODE_W-1:0] rsp_node
);

    win_start_t         start_q [WINDOWS];
    win_end_t           end_q   [WINDOWS];
    logic [WINDOWS-1:0] win_hit;

    logic unused_offset;
    assign unused_offset = ^cfg_addr[1:0];

    mem_route_regs #(.WINDOWS(WINDOWS)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .cfg_we    (cfg_we),
        .cfg_sel   (cfg_addr[CFG_AW-1:2]),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .start_q   (start_q),
        .end_q     (end_q)
    );

    for (genvar i = 0; i < WINDOWS; i++) begin : g_match
        mem_route_match u_match (
            .win_start (start_q[i]),
            .win_end   (end_q[i]),
            .req_addr  (req_addr),
            .req_write (req_write),
            .hit       (win_hit[i])
        );
    end

    mem_route_pick #(.WINDOWS(WINDOWS)) u_pick (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .win_hit   (win_hit),
        .end_q     (end_q),
        .rsp_hit   (rsp_hit),
        .rsp_node  (rsp_node)
    );

endmodule

// File: rtl/mem_route_dec_chk.sv
module mem_route_dec_chk
    import mem_route_pkg::*;
#(
    parameter int unsigned CFG_AW = 6
) (
    input logic              clk,
    input logic              rst,
    input logic              cfg_we,
    input logic [CFG_AW-1:0] cfg_addr,
    input logic [REG_W-1:0]  cfg_wdata,
    input logic [REG_W-1:0]  cfg_rdata,
    input logic              req_valid,
    input logic              rsp_hit,
    input logic [NODE_W-1:0] rsp_node
);

    AST_RDATA_RESV_ZERO: assert property (@(posedge clk) disable iff (rst)
        (cfg_rdata & ~(cfg_addr[2] ? END_KEEP : START_KEEP)) == '0); // R2

    AST_WRITE_READBACK: assert property (@(posedge clk) disable iff (rst)
        cfg_we |=> (!$stable(cfg_addr) ||
                    cfg_rdata == ($past(cfg_wdata) & ($past(cfg_addr[2]) ? END_KEEP : START_KEEP)))); // R2

    AST_MISS_NODE_ZERO: assert property (@(posedge clk) disable iff (rst)
        !rsp_hit |-> rsp_node == '0); // R8

    AST_IDLE_NO_HIT: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_hit); // R8

    AST_HIT_NEEDS_REQ: assert property (@(posedge clk) disable iff (rst)
        rsp_hit |-> $past(req_valid)); // R9

endmodule

bind mem_route_dec mem_route_dec_chk #(.CFG_AW(CFG_AW)) u_chk (.*);

// File: tb/mem_route_dec_bench.sv
`timescale 1ns/1ps
module mem_route_dec_bench;
    import mem_route_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [5:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        req_valid = 1'b0;
    logic [39:0] req_addr = '0;
    logic        req_write = 1'b0;
    logic        rsp_hit;
    logic [2:0]  rsp_node;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    mem_route_dec u_mem_route_dec (.*);

    // {address, write, expected hit, expected node}
    localparam int NV = 17;
    localparam logic [44:0] VECS [NV] = '{
        {40'h00_0000_0000, 1'b0, 1'b1, 3'd3},   // R3 lower bound of window 0
        {40'h00_0FFF_FFFF, 1'b1, 1'b1, 3'd3},   // R3 upper bound inclusive
        {40'h00_0500_0000, 1'b0, 1'b1, 3'd3},   // R7 window 0 beats window 6
        {40'h00_1000_0000, 1'b0, 1'b1, 3'd5},   // R4 read allowed
        {40'h00_1000_0000, 1'b1, 1'b0, 3'd0},   // R4 write not allowed
        {40'h00_2000_1000, 1'b0, 1'b1, 3'd6},   // R5 code 011 select 001
        {40'h00_2000_5000, 1'b0, 1'b0, 3'd0},   // R5 bit14 mismatch, bit12 mismatch
        {40'h00_2000_0000, 1'b0, 1'b1, 3'd2},   // R5 code 001 fallback
        {40'h00_2000_3000, 1'b1, 1'b1, 3'd6},   // R5 bit13 ignored under 011
        {40'h00_3000_6000, 1'b0, 1'b1, 3'd7},   // R5 code 111 exact
        {40'h00_3000_7000, 1'b0, 1'b0, 3'd0},   // R5 code 111 mismatch
        {40'h00_4000_0000, 1'b0, 1'b0, 3'd0},   // R6 reserved code
        {40'h00_5000_0000, 1'b0, 1'b0, 3'd0},   // R4 end loaded, start never written
        {40'h00_6000_0000, 1'b0, 1'b0, 3'd0},   // R8 outside all windows
        {40'hFF_FF00_0000, 1'b1, 1'b0, 3'd0},   // R8 top of space
        {40'h00_1FFF_FFFF, 1'b0, 1'b1, 3'd5},   // R3 upper bound of window 1
        {40'h00_3FFF_E000, 1'b1, 1'b1, 3'd7}    // R3 R5 last tag, select 110
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic rd_check(input string req, input logic [5:0] a, input logic [31:0] exp);
        @(negedge clk);
        cfg_addr = a;
        #1;
        check(req, cfg_rdata, exp);
    endtask

    task automatic send(input logic [39:0] a, input logic w);
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_write = w;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        check("R1 rsp_hit", {31'b0, rsp_hit}, 32'd0);
        check("R1 rsp_node", {29'b0, rsp_node}, 32'd0);
        rd_check("R1 start reg", 6'h10, 32'h0);
        rd_check("R1 end reg", 6'h3C, 32'h0);

        // R2: reserved bits dropped, offset bits 1:0 ignored
        wr_reg(6'h38, 32'hFFFF_FFFF);
        rd_check("R2 start keep", 6'h3B, 32'hFFFF_0703);
        wr_reg(6'h38, 32'h0);
        wr_reg(6'h34, 32'hAAAA_F8F9);
        rd_check("R2 end keep", 6'h34, 32'hAAAA_0001);

        // window map
        wr_reg(6'h04, 32'h000F_0003); wr_reg(6'h00, 32'h0000_0003);
        wr_reg(6'h0C, 32'h001F_0005); wr_reg(6'h08, 32'h0010_0001);
        wr_reg(6'h14, 32'h002F_0106); wr_reg(6'h10, 32'h0020_0303);
        wr_reg(6'h1C, 32'h002F_0002); wr_reg(6'h18, 32'h0020_0103);
        wr_reg(6'h24, 32'h003F_0607); wr_reg(6'h20, 32'h0030_0703);
        wr_reg(6'h2C, 32'h004F_0004); wr_reg(6'h28, 32'h0040_0203);
        wr_reg(6'h34, 32'h0006_0001); wr_reg(6'h30, 32'h0005_0003);
        wr_reg(6'h3C, 32'h005F_0002);
        rd_check("R2 start readback", 6'h10, 32'h0020_0303);
        rd_check("R2 end readback", 6'h14, 32'h002F_0106);

        for (int i = 0; i < NV; i++) begin
            send(VECS[i][44:5], VECS[i][4]);
            check($sformatf("R3-table vec%0d hit", i), {31'b0, rsp_hit}, {31'b0, VECS[i][3]});
            check($sformatf("R7 R8 vec%0d node", i), {29'b0, rsp_node}, {29'b0, VECS[i][2:0]});
        end

        // R9: no response before the edge, response right after it
        @(negedge clk);
        req_valid = 1'b1; req_addr = 40'h00_1000_0000; req_write = 1'b0;
        #1;
        check("R9 before edge", {31'b0, rsp_hit}, 32'd0);
        @(negedge clk);
        check("R9 after edge", {28'b0, rsp_hit, rsp_node}, 32'hD);

        // R8: hitting address with req_valid low
        req_valid = 1'b0;
        @(negedge clk);
        check("R8 idle", {28'b0, rsp_hit, rsp_node}, 32'h0);

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #400000;
        if (!finished) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule